// File: doc/BRIEF.md
# Status Flag Register Unit

This unit keeps the eight-bit condition byte of a small eight-bit processor core. Each cycle it may receive a result from the arithmetic or shift datapath, tagged with an operation class, and folds that result into the carry, zero, sign, overflow, decimal-adjust and half-carry bits according to the rules of that class. Three dedicated classes force, clear or invert the carry on their own. Two low bits are left for software and are never touched by any operation.

The byte also sits in the register file at address 252, where a store replaces it whole and a load returns it. On an interrupt return the saved byte is loaded back in a single cycle. A restore outranks a store, and a store outranks an operation arriving in the same cycle. The individual test flags are brought out as separate pins for the branch-condition logic.

Results arrive as a plain strobe (`op_valid`) with no ready signal. The unit takes one update per cycle and never stalls, so upstream logic has no back-pressure to handle.

Top module: `status_flag_unit`

## Requirements
- R1: While reset is held and after it is released, all eight bits read 0. The bit layout of `flags` is C=7, Z=6, S=5, V=4, D=3, H=2, F2=1, F1=0. `flag_c`, `flag_z`, `flag_s` and `flag_v` mirror bits 7, 6, 5 and 4.
- R2: With `op_class`=1 (arithmetic), one cycle after the strobe the bits are set as follows: C=`alu_carry`, Z=1 exactly when `alu_result` is zero, S=bit 7 of `alu_result`, V=`alu_ovf`, D=`alu_sub` and H=`alu_half`.
- R3: No operation class ever changes F1 or F2.
- R4: With `op_class`=3 (shift/rotate), C takes `alu_carry` (the last bit shifted out), Z and S follow the result, and V takes `alu_ovf`. D and H keep their values.
- R5: With `op_class`=2 (logical), Z and S follow the result and V is cleared. C, D and H keep their values.
- R6: With `op_class`=4 (bit test), only Z changes, and it becomes 1 exactly when `alu_result` (the masked value) is zero.
- R7: `op_class` 5 sets C, 6 clears C and 7 inverts C. None of them changes any other bit.
- R8: A store with `wr_en`=1 and `wr_addr`=252 replaces the whole byte with `wr_data` on the next cycle. A store to any other address has no effect.
- R9: When `rd_addr`=252, `rd_hit` is 1 and `rd_data` shows the current byte in the same cycle. For any other address both outputs are 0.
- R10: When `rti_valid` is 1, the whole byte equals `rti_data` one cycle later.
- R11: In a single cycle, a restore wins over a store and an operation, and a store to 252 wins over an operation.
- R12: With `op_valid`=0 or `op_class`=0 (none), the byte does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation result strobe |
| op_class | input | 3 | Operation class code (see requirements) |
| alu_result | input | 8 | Result byte of the operation |
| alu_carry | input | 1 | Carry/borrow out, or bit shifted out |
| alu_ovf | input | 1 | Signed overflow of the operation |
| alu_half | input | 1 | Carry out of bit 3 |
| alu_sub | input | 1 | Operation was a subtraction |
| wr_en | input | 1 | Register-file store strobe |
| wr_addr | input | 8 | Register-file store address |
| wr_data | input | 8 | Register-file store data |
| rd_addr | input | 8 | Register-file load address |
| rd_data | output | 8 | Load data, flag byte on a hit |
| rd_hit | output | 1 | Load address selects this register |
| rti_valid | input | 1 | Interrupt-return restore strobe |
| rti_data | input | 8 | Saved byte to restore |
| flags | output | 8 | Current flag byte |
| flag_c | output | 1 | Carry |
| flag_z | output | 1 | Zero |
| flag_s | output | 1 | Sign |
| flag_v | output | 1 | Overflow |

## Verification
The properties assume that every input is driven to a known level on each rising edge after reset. Because all eight class codes are defined, they place no limit on `op_class`. They also assume that the register is reached only through `wr_addr` at 252, so a store anywhere else counts as no store. The directed stimulus changes inputs only on the falling edge, holds each strobe for exactly one rising edge, and includes both matching and non-matching addresses. It also drives junk values on the datapath inputs during carry-only and idle cycles, so that any bit leaking through would show up.

// File: rtl/flag_pkg.sv
`timescale 1ns/1ps
package flag_pkg;
  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ARITH = 3'd1,
    OPC_LOGIC = 3'd2,
    OPC_SHIFT = 3'd3,
    OPC_TEST  = 3'd4,
    OPC_SETC  = 3'd5,
    OPC_CLRC  = 3'd6,
    OPC_INVC  = 3'd7
  } op_class_e;

  localparam int unsigned FLAG_W = 8;
  localparam int unsigned BIT_C  = 7;
  localparam int unsigned BIT_Z  = 6;
  localparam int unsigned BIT_S  = 5;
  localparam int unsigned BIT_V  = 4;
  localparam int unsigned BIT_D  = 3;
  localparam int unsigned BIT_H  = 2;
  localparam int unsigned BIT_U2 = 1;
  localparam int unsigned BIT_U1 = 0;
endpackage

// File: rtl/flag_op_update.sv
`timescale 1ns/1ps
module flag_op_update
  import flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [FLAG_W-1:0] cur,
  input  logic              op_valid,
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] result,
  input  logic              carry_in,
  input  logic              ovf_in,
  input  logic              half_in,
  input  logic              sub_in,
  output logic [FLAG_W-1:0] nxt
);
  localparam int unsigned MSB = DATA_W - 1;

  logic      is_zero;
  op_class_e cls;

  assign is_zero = ~|result;
  assign cls     = op_class_e'(op_class);

  always_comb begin
    nxt = cur;
    if (op_valid) begin
      unique case (cls)
        OPC_ARITH: begin
          nxt[BIT_C] = carry_in;
          nxt[BIT_Z] = is_zero;
          nxt[BIT_S] = result[MSB];
          nxt[BIT_V] = ovf_in;
          nxt[BIT_D] = sub_in;
          nxt[BIT_H] = half_in;
        end
        OPC_LOGIC: begin
          nxt[BIT_Z] = is_zero;
          nxt[BIT_S] = result[MSB];
          nxt[BIT_V] = 1'b0;
        end
        OPC_SHIFT: begin
          nxt[BIT_C] = carry_in;
          nxt[BIT_Z] = is_zero;
          nxt[BIT_S] = result[MSB];
          nxt[BIT_V] = ovf_in;
        end
        OPC_TEST:  nxt[BIT_Z] = is_zero;
        OPC_SETC:  nxt[BIT_C] = 1'b1;
        OPC_CLRC:  nxt[BIT_C] = 1'b0;
        OPC_INVC:  nxt[BIT_C] = ~cur[BIT_C];
        default:   nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/flag_reg_access.sv
`timescale 1ns/1ps
module flag_reg_access
  import flag_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hFC
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [FLAG_W-1:0] cur,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic [FLAG_W-1:0] rd_data
);
  assign wr_hit  = wr_en && (wr_addr == FLAG_ADDR);
  assign rd_hit  = (rd_addr == FLAG_ADDR);
  assign rd_data = rd_hit ? cur : '0;
endmodule

// File: rtl/status_flag_unit.sv
`timescale 1ns/1ps
module status_flag_unit
  import flag_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              alu_half,
  input  logic              alu_sub,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_hit,
  input  logic              rti_valid,
  input  logic [7:0]        rti_data,
  output logic [7:0]        flags,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_v
);
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] op_nxt;
  logic              wr_hit;

  flag_op_update #(.DATA_W(DATA_W)) u_update (
    .cur      (flag_q),
    .op_valid (op_valid),
    .op_class (op_class),
    .result   (alu_result),
    .carry_in (alu_carry),
    .ovf_in   (alu_ovf),
    .half_in  (alu_half),
    .sub_in   (alu_sub),
    .nxt      (op_nxt)
  );

  flag_reg_access #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_access (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .cur     (flag_q),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit),
    .rd_data (rd_data)
  );

  // Restore first, then store, then operation result.
  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= '0;
    else if (rti_valid) flag_q <= rti_data;
    else if (wr_hit)    flag_q <= wr_data;
    else                flag_q <= op_nxt;
  end

  assign flags  = flag_q;
  assign flag_c = flag_q[BIT_C];
  assign flag_z = flag_q[BIT_Z];
  assign flag_s = flag_q[BIT_S];
  assign flag_v = flag_q[BIT_V];
endmodule

// File: rtl/status_flag_unit_chk.sv
`timescale 1ns/1ps
module status_flag_unit_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_class,
  input logic [DATA_W-1:0] alu_result,
  input logic              alu_carry,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rti_valid,
  input logic [7:0]        rti_data,
  input logic [7:0]        flags,
  input logic              flag_c
);
  logic store_sel;
  logic quiet;
  assign store_sel = wr_en && (wr_addr == FLAG_ADDR);
  assign quiet     = !rti_valid && !store_sel;

  AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rti_valid |=> flags == $past(rti_data)); // R10

  AST_STORE_OVER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rti_valid && store_sel) |=> flags == $past(wr_data)); // R11

  AST_USER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(flags[1:0])); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && (!op_valid || op_class == 3'd0)) |=> $stable(flags)); // R12

  AST_CARRY_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && op_valid && op_class == 3'd7) |=> (flag_c != $past(flag_c)) && $stable(flags[6:0])); // R7

  AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && op_valid && op_class == 3'd5) |=> flag_c && $stable(flags[6:0])); // R7

  AST_ARITH_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && op_valid && op_class == 3'd1) |=>
      (flags[6] == ($past(alu_result) == '0)) && (flags[5] == $past(alu_result[DATA_W-1]))
      && (flags[7] == $past(alu_carry))); // R2

  AST_TEST_Z_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && op_valid && op_class == 3'd4) |=>
      (flags[6] == ($past(alu_result) == '0)) && $stable(flags[7]) && $stable(flags[5:0])); // R6
endmodule

bind status_flag_unit status_flag_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)
) i_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
  .alu_result(alu_result), .alu_carry(alu_carry), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .rti_valid(rti_valid),
  .rti_data(rti_data), .flags(flags), .flag_c(flag_c)
);

// File: tb/test_status_flag_unit.sv
`timescale 1ns/1ps
module test_status_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_class;
  logic [7:0] alu_result;
  logic       alu_carry, alu_ovf, alu_half, alu_sub;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic       rd_hit;
  logic       rti_valid;
  logic [7:0] rti_data, flags;
  logic       flag_c, flag_z, flag_s, flag_v;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  status_flag_unit i_status_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
    .alu_half(alu_half), .alu_sub(alu_sub), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit),
    .rti_valid(rti_valid), .rti_data(rti_data), .flags(flags),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_class = 3'd0; alu_result = 8'h00;
    alu_carry = 0; alu_ovf = 0; alu_half = 0; alu_sub = 0;
    wr_en = 0; wr_addr = 8'h00; wr_data = 8'h00;
    rti_valid = 0; rti_data = 8'h00;
  endtask

  // Drive at falling edge, one rising edge, sample at next falling edge.
  task automatic step_op(input logic v, input logic [2:0] cls, input logic [7:0] res,
                         input logic c, input logic o, input logic h, input logic s);
    @(negedge clk);
    op_valid = v; op_class = cls; alu_result = res;
    alu_carry = c; alu_ovf = o; alu_half = h; alu_sub = s;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic step_store(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    idle_inputs(); rd_addr = 8'h00; rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset held", flags, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", flags, 8'h00);
  endtask

  task automatic t_arith();
    step_op(1, 3'd1, 8'h00, 1, 0, 1, 0);
    check("R2 zero result", flags, 8'hC4);
    step_op(1, 3'd1, 8'h80, 0, 1, 0, 1);
    check("R2 negative result", flags, 8'h38);
  endtask

  task automatic t_store();
    step_store(8'hFC, 8'h03);
    check("R8 store hit", flags, 8'h03);
    step_store(8'hFD, 8'hFF);
    check("R8 store miss", flags, 8'h03);
  endtask

  task automatic t_user_bits();
    step_op(1, 3'd1, 8'h00, 1, 1, 1, 1);
    check("R3 arith keeps user bits", flags, 8'hDF);
  endtask

  task automatic t_shift();
    step_op(1, 3'd3, 8'h7F, 0, 0, 0, 0);
    check("R4 shift", flags, 8'h0F);
  endtask

  task automatic t_logic();
    step_store(8'hFC, 8'h93);
    step_op(1, 3'd2, 8'hF0, 0, 1, 1, 1);
    check("R5 logic", flags, 8'hA3);
  endtask

  task automatic t_test();
    step_op(1, 3'd4, 8'h00, 0, 1, 1, 1);
    check("R6 test zero", flags, 8'hE3);
    step_op(1, 3'd4, 8'h04, 0, 0, 0, 0);
    check("R6 test nonzero", flags, 8'hA3);
  endtask

  task automatic t_carry();
    step_op(1, 3'd6, 8'h00, 1, 1, 1, 1);
    check("R7 clear carry", flags, 8'h23);
    step_op(1, 3'd7, 8'hFF, 0, 0, 0, 0);
    check("R7 invert carry up", flags, 8'hA3);
    step_op(1, 3'd7, 8'h00, 0, 1, 1, 1);
    check("R7 invert carry down", flags, 8'h23);
    step_op(1, 3'd5, 8'h00, 0, 1, 1, 1);
    check("R7 set carry", flags, 8'hA3);
  endtask

  task automatic t_idle();
    step_op(0, 3'd1, 8'h00, 0, 1, 1, 1);
    check("R12 no strobe", flags, 8'hA3);
    step_op(1, 3'd0, 8'h00, 0, 1, 1, 1);
    check("R12 class none", flags, 8'hA3);
    check("R1 pins", {flag_c, flag_z, flag_s, flag_v, 4'h0}, 8'hA0);
  endtask

  task automatic t_read();
    rd_addr = 8'hFC; #1;
    check("R9 read hit data", rd_data, 8'hA3);
    check("R9 read hit flag", {7'h0, rd_hit}, 8'h01);
    rd_addr = 8'h10; #1;
    check("R9 read miss data", rd_data, 8'h00);
    check("R9 read miss flag", {7'h0, rd_hit}, 8'h00);
    rd_addr = 8'h00;
  endtask

  task automatic t_restore();
    @(negedge clk);
    rti_valid = 1; rti_data = 8'h5A;
    @(negedge clk);
    idle_inputs();
    check("R10 restore", flags, 8'h5A);
  endtask

  task automatic t_priority();
    @(negedge clk);
    rti_valid = 1; rti_data = 8'h11;
    wr_en = 1; wr_addr = 8'hFC; wr_data = 8'h22;
    op_valid = 1; op_class = 3'd1; alu_result = 8'h80;
    @(negedge clk);
    idle_inputs();
    check("R11 restore wins", flags, 8'h11);
    @(negedge clk);
    wr_en = 1; wr_addr = 8'hFC; wr_data = 8'h66;
    op_valid = 1; op_class = 3'd5;
    @(negedge clk);
    idle_inputs();
    check("R11 store wins", flags, 8'h66);
    @(negedge clk);
    wr_en = 1; wr_addr = 8'h00; wr_data = 8'h00;
    op_valid = 1; op_class = 3'd5;
    @(negedge clk);
    idle_inputs();
    check("R11 miss lets op through", flags, 8'hE6);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_store();
    t_user_bits();
    t_shift();
    t_logic();
    t_test();
    t_carry();
    t_idle();
    t_read();
    t_restore();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule